// File: doc/BRIEF.md
# Serial Receiver with Line Status

This block turns an asynchronous serial line into parallel characters. The line is sampled on a clock enable that pulses sixteen times per bit. Each frame has a start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop bit. The block shifts the bits into an assembly register. When a frame completes, it copies the character into a receive buffer that software reads.

Alongside the buffer it keeps a line status byte. That byte holds data-ready, overrun, parity, framing and break flags, and mirrors two transmitter status bits that come in from outside. A request output goes high while any receive flag is set.

A loopback select routes the transmitter's serial output into the receiver in place of the external pin. This allows a self-test without wiring.

Top module: `serrx_core`

## Requirements
- R1: After reset, `rx_data` is 0, `irq` is 0 and `line_status` bits 0 to 4 and bit 7 are 0.
- R2: Data bits arrive least significant bit first. The `word_len` code selects 0=5, 1=6, 2=7 or 3=8 bits. The character is right-aligned in `rx_data`, and the bits above its width are 0.
- R3: A low level seen on a tick starts a frame, and it is checked again 8 ticks later. If the line is high at that second sample, the start is dropped and no status or data changes. Later bits are sampled every 16 ticks.
- R4: With `par_en`=1, one parity bit follows the data. `par_even`=1 expects an even count of ones over data and parity, and 0 expects an odd count. A mismatch sets `line_status` bit 2.
- R5: A stop bit sampled low sets `line_status` bit 3. The receiver then waits for the line to return high before it looks for a new start.
- R6: A frame whose data, parity and stop bits are all 0 sets `line_status` bit 4 together with bit 3. It loads a single 0 character, and nothing more is received until the line goes high.
- R7: A character that completes while bit 0 is still set sets `line_status` bit 1, and the new character replaces the buffer contents.
- R8: A completed character sets `line_status` bit 0. A one-cycle `rd_data` pulse clears it.
- R9: A one-cycle `rd_status` pulse clears bits 1 to 4 and leaves bit 0 unchanged.
- R10: With `loop_en`=1 the receiver takes `loop_tx` and ignores `rx_pin`. With `loop_en`=0 it takes `rx_pin`.
- R11: `line_status` bit 5 equals `tx_hold_empty`, bit 6 equals `tx_shift_empty`, and bit 7 is 0.
- R12: `irq` is 1 exactly when any of `line_status` bits 0 to 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulsing 16 times per bit period |
| rx_pin | input | 1 | External serial input, idle high |
| loop_tx | input | 1 | Transmitter serial output for loopback |
| loop_en | input | 1 | Select loop_tx as the receiver input |
| word_len | input | 2 | Character width code (5 + code bits) |
| par_en | input | 1 | Expect a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| rd_data | input | 1 | Read strobe for the receive buffer |
| rd_status | input | 1 | Read strobe for the status byte |
| tx_hold_empty | input | 1 | Transmitter holding register empty |
| tx_shift_empty | input | 1 | Transmitter shifter empty |
| rx_data | output | 8 | Receive buffer |
| line_status | output | 8 | Status byte |
| irq | output | 1 | Receive request |

## Verification
If the bit counter or tick counter is off by one, the character in `rx_data` comes out shifted or misaligned. It also raises a false framing flag. Both appear one character time after the frame starts, which is the first moment the buffer loads. A flag register that fails to clear or set shows on `line_status` and `irq` at the next clock edge after a read strobe or a frame completion. A start or break hunting state that is stuck shows as a missing character, or as an extra zero character after a long low line.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_err_t;

endpackage

// File: rtl/serrx_linesel.sv
module serrx_linesel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic loop_tx,
  input  logic loop_en,
  output logic line_o
);

  logic                   sel_bit;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  assign sel_bit = loop_en ? loop_tx : pin;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], sel_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign line_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/serrx_frame.sv
module serrx_frame
  import serrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output rx_err_t           err_o
);

  localparam int CNT_W = $clog2(OS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OS / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS - 1);
  localparam logic [BIT_W-1:0] IDX_MIN  = BIT_W'(DATA_W - 4);
  localparam logic [BIT_W-1:0] IDX_TOP  = BIT_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bits_q, bits_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              parbit_q, parbit_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] data_q, data_d;
  rx_err_t           err_q, err_d;

  logic [BIT_W-1:0]  last_idx;
  logic [DATA_W-1:0] aligned;
  logic              par_bad;
  logic              all_zero;

  assign last_idx = IDX_MIN + BIT_W'(word_len);
  assign aligned  = shreg_q >> (IDX_TOP - last_idx);
  assign par_bad  = par_en & ((^aligned) ^ parbit_q ^ ~par_even);
  assign all_zero = (aligned == '0) && (!par_en || !parbit_q);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bits_d   = bits_q;
    shreg_d  = shreg_q;
    parbit_d = parbit_q;
    done_d   = 1'b0;
    data_d   = data_q;
    err_d    = err_q;
    case (state_q)
      ST_IDLE: begin
        if (tick && !line) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
      end
      ST_START: begin
        if (tick) begin
          if (cnt_q == CNT_MID) begin
            cnt_d   = '0;
            bits_d  = '0;
            state_d = line ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_d   = '0;
            shreg_d = {line, shreg_q[DATA_W-1:1]};
            if (bits_q == last_idx) state_d = par_en ? ST_PARITY : ST_STOP;
            else                    bits_d  = bits_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_d    = '0;
            parbit_d = line;
            state_d  = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_d     = '0;
            done_d    = 1'b1;
            data_d    = aligned;
            err_d.par = par_bad;
            err_d.frm = !line;
            err_d.brk = !line && all_zero;
            state_d   = line ? ST_IDLE : ST_HOLD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (line) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      bits_q   <= '0;
      shreg_q  <= '0;
      parbit_q <= 1'b0;
      done_q   <= 1'b0;
      data_q   <= '0;
      err_q    <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      bits_q   <= bits_d;
      shreg_q  <= shreg_d;
      parbit_q <= parbit_d;
      done_q   <= done_d;
      data_q   <= data_d;
      err_q    <= err_d;
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign err_o  = err_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
  AST_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick && cnt_q == CNT_MID && line) |=> state_q == ST_IDLE); // R3
  AST_BREAK_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q.brk) |-> (err_q.frm && data_q == '0)); // R6
  AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !line) |=> state_q == ST_HOLD); // R5

endmodule

// File: rtl/serrx_status.sv
module serrx_status
  import serrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  input  rx_err_t           err,
  input  logic              rd_data,
  input  logic              rd_status,
  input  logic              tx_hold_empty,
  input  logic              tx_shift_empty,
  output logic [DATA_W-1:0] rx_data,
  output logic [7:0]        line_status,
  output logic              irq
);

  logic [DATA_W-1:0] buf_q, buf_d;
  logic dr_q, dr_d;
  logic oe_q, oe_d;
  logic pe_q, pe_d;
  logic fe_q, fe_d;
  logic bi_q, bi_d;

  always_comb begin
    buf_d = done ? data : buf_q;
    dr_d  = done ? 1'b1 : (rd_data ? 1'b0 : dr_q);
    oe_d  = (done && dr_q && !rd_data) ? 1'b1 : (rd_status ? 1'b0 : oe_q);
    pe_d  = (done && err.par) ? 1'b1 : (rd_status ? 1'b0 : pe_q);
    fe_d  = (done && err.frm) ? 1'b1 : (rd_status ? 1'b0 : fe_q);
    bi_d  = (done && err.brk) ? 1'b1 : (rd_status ? 1'b0 : bi_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      dr_q  <= 1'b0;
      oe_q  <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      buf_q <= buf_d;
      dr_q  <= dr_d;
      oe_q  <= oe_d;
      pe_q  <= pe_d;
      fe_q  <= fe_d;
      bi_q  <= bi_d;
    end
  end

  assign rx_data     = buf_q;
  assign line_status = {1'b0, tx_shift_empty, tx_hold_empty, bi_q, fe_q, pe_q, oe_q, dr_q};
  assign irq         = dr_q | oe_q | pe_q | fe_q | bi_q;

  AST_DR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> dr_q); // R8
  AST_NO_OVERRUN_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dr_q && !rd_data) |=> oe_q); // R7
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !done) |=> !(oe_q || pe_q || fe_q || bi_q)); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done)); // R12

endmodule

// File: rtl/serrx_core.sv
module serrx_core
  import serrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_pin,
  input  logic              loop_tx,
  input  logic              loop_en,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              rd_data,
  input  logic              rd_status,
  input  logic              tx_hold_empty,
  input  logic              tx_shift_empty,
  output logic [DATA_W-1:0] rx_data,
  output logic [7:0]        line_status,
  output logic              irq
);

  logic              rst_meta_q;
  logic              rst_sync_q;
  logic              line;
  logic              done;
  logic [DATA_W-1:0] frame_data;
  rx_err_t           frame_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  serrx_linesel #(.SYNC_STAGES(SYNC_STAGES)) u_linesel (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .pin     (rx_pin),
    .loop_tx (loop_tx),
    .loop_en (loop_en),
    .line_o  (line)
  );

  serrx_frame #(.DATA_W(DATA_W), .OS(OS)) u_frame (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .tick     (tick16),
    .line     (line),
    .word_len (word_len),
    .par_en   (par_en),
    .par_even (par_even),
    .done_o   (done),
    .data_o   (frame_data),
    .err_o    (frame_err)
  );

  serrx_status #(.DATA_W(DATA_W)) u_status (
    .clk            (clk),
    .rst_n          (rst_sync_q),
    .done           (done),
    .data           (frame_data),
    .err            (frame_err),
    .rd_data        (rd_data),
    .rd_status      (rd_status),
    .tx_hold_empty  (tx_hold_empty),
    .tx_shift_empty (tx_shift_empty),
    .rx_data        (rx_data),
    .line_status    (line_status),
    .irq            (irq)
  );

endmodule

// File: tb/serrx_core_bench.sv
`timescale 1ns/1ps
module serrx_core_bench;

  localparam int BIT_CYC = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick16;
  logic       rx_pin;
  logic       loop_tx;
  logic       loop_en;
  logic [1:0] word_len;
  logic       par_en;
  logic       par_even;
  logic       rd_data;
  logic       rd_status;
  logic       tx_hold_empty;
  logic       tx_shift_empty;
  logic [7:0] rx_data;
  logic [7:0] line_status;
  logic       irq;

  int  n_checks = 0;
  int  n_bad    = 0;
  bit  use_loop = 1'b0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  serrx_core u_serrx_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick16         (tick16),
    .rx_pin         (rx_pin),
    .loop_tx        (loop_tx),
    .loop_en        (loop_en),
    .word_len       (word_len),
    .par_en         (par_en),
    .par_even       (par_even),
    .rd_data        (rd_data),
    .rd_status      (rd_status),
    .tx_hold_empty  (tx_hold_empty),
    .tx_shift_empty (tx_shift_empty),
    .rx_data        (rx_data),
    .line_status    (line_status),
    .irq            (irq)
  );

  initial begin
    tick16 = 1'b0;
    forever begin
      repeat (3) begin @(negedge clk); tick16 = 1'b0; end
      @(negedge clk); tick16 = 1'b1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic v, input int cycles);
    if (use_loop) loop_tx = v;
    else          rx_pin  = v;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nbits, input bit with_par,
                      input logic pbit, input logic stopv);
    put(1'b0, BIT_CYC);
    for (int i = 0; i < nbits; i++) put(d[i], BIT_CYC);
    if (with_par) put(pbit, BIT_CYC);
    put(stopv, BIT_CYC);
    put(1'b1, BIT_CYC / 2);
  endtask

  task automatic pulse_rd_data();
    @(negedge clk); rd_data = 1'b1;
    @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic pulse_rd_status();
    @(negedge clk); rd_status = 1'b1;
    @(negedge clk); rd_status = 1'b0;
  endtask

  task automatic clear_all();
    pulse_rd_data();
    pulse_rd_status();
  endtask

  task automatic t_reset();
    check("R1 data", {24'd0, rx_data}, 32'h0);
    check("R1 status", {24'd0, line_status}, 32'h20);
    check("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_basic();
    word_len = 2'd3; par_en = 1'b0;
    send(8'hA5, 8, 1'b0, 1'b0, 1'b1);
    check("R2 data 8 bit", {24'd0, rx_data}, 32'hA5);
    check("R8 ready set", {24'd0, line_status}, 32'h21);
    check("R12 irq on ready", {31'd0, irq}, 32'h1);
    pulse_rd_data();
    check("R8 read clears ready", {24'd0, line_status}, 32'h20);
    check("R12 irq cleared", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_widths();
    word_len = 2'd0;
    send(8'hF5, 5, 1'b0, 1'b0, 1'b1);
    check("R2 data 5 bit", {24'd0, rx_data}, 32'h15);
    pulse_rd_data();
    word_len = 2'd1;
    send(8'hEB, 6, 1'b0, 1'b0, 1'b1);
    check("R2 data 6 bit", {24'd0, rx_data}, 32'h2B);
    check("R2 no error 6 bit", {24'd0, line_status}, 32'h21);
    pulse_rd_data();
    word_len = 2'd3;
  endtask

  task automatic t_parity();
    word_len = 2'd2; par_en = 1'b1; par_even = 1'b1;
    send(8'h5A, 7, 1'b1, ^(8'h5A & 8'h7F), 1'b1);
    check("R4 even ok data", {24'd0, rx_data}, 32'h5A);
    check("R4 even ok status", {24'd0, line_status}, 32'h21);
    pulse_rd_data();
    send(8'h5A, 7, 1'b1, ~^(8'h5A & 8'h7F), 1'b1);
    check("R4 even bad status", {24'd0, line_status}, 32'h25);
    pulse_rd_data();
    check("R12 irq held by error", {31'd0, irq}, 32'h1);
    pulse_rd_status();
    check("R9 parity cleared", {24'd0, line_status}, 32'h20);
    word_len = 2'd3; par_even = 1'b0;
    send(8'h01, 8, 1'b1, 1'b0, 1'b1);
    check("R4 odd ok status", {24'd0, line_status}, 32'h21);
    pulse_rd_data();
    send(8'h03, 8, 1'b1, 1'b0, 1'b1);
    check("R4 odd bad status", {24'd0, line_status}, 32'h25);
    clear_all();
    par_en = 1'b0; par_even = 1'b1;
  endtask

  task automatic t_framing();
    send(8'h33, 8, 1'b0, 1'b0, 1'b0);
    check("R5 framing data", {24'd0, rx_data}, 32'h33);
    check("R5 framing status", {24'd0, line_status}, 32'h29);
    clear_all();
    send(8'h6E, 8, 1'b0, 1'b0, 1'b1);
    check("R5 next frame after error", {24'd0, rx_data}, 32'h6E);
    pulse_rd_data();
  endtask

  task automatic t_break();
    put(1'b0, 12 * BIT_CYC);
    check("R6 break status", {24'd0, line_status}, 32'h39);
    check("R6 break data", {24'd0, rx_data}, 32'h0);
    clear_all();
    put(1'b0, 4 * BIT_CYC);
    check("R6 single char while low", {24'd0, line_status}, 32'h20);
    put(1'b1, 2 * BIT_CYC);
    check("R6 no char after release", {24'd0, line_status}, 32'h20);
  endtask

  task automatic t_overrun();
    send(8'hA5, 8, 1'b0, 1'b0, 1'b1);
    send(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    check("R7 overrun status", {24'd0, line_status}, 32'h23);
    check("R7 newest data kept", {24'd0, rx_data}, 32'h3C);
    pulse_rd_status();
    check("R9 clears overrun keeps ready", {24'd0, line_status}, 32'h21);
    pulse_rd_data();
  endtask

  task automatic t_glitch();
    put(1'b0, 8);
    put(1'b1, 3 * BIT_CYC);
    check("R3 glitch ignored", {24'd0, line_status}, 32'h20);
    send(8'h81, 8, 1'b0, 1'b0, 1'b1);
    check("R3 frame after glitch", {24'd0, rx_data}, 32'h81);
    pulse_rd_data();
  endtask

  task automatic t_loop();
    loop_tx = 1'b1;
    @(negedge clk); loop_en = 1'b1;
    repeat (8) @(negedge clk);
    send(8'h42, 8, 1'b0, 1'b0, 1'b1);
    check("R10 pin ignored in loopback", {24'd0, line_status}, 32'h20);
    rx_pin = 1'b0;
    use_loop = 1'b1;
    send(8'hC3, 8, 1'b0, 1'b0, 1'b1);
    use_loop = 1'b0;
    check("R10 loop data", {24'd0, rx_data}, 32'hC3);
    check("R10 loop status", {24'd0, line_status}, 32'h21);
    pulse_rd_data();
    rx_pin = 1'b1;
    repeat (8) @(negedge clk);
    loop_en = 1'b0;
    repeat (8) @(negedge clk);
    send(8'h17, 8, 1'b0, 1'b0, 1'b1);
    check("R10 pin used again", {24'd0, rx_data}, 32'h17);
    pulse_rd_data();
  endtask

  task automatic t_txbits();
    @(negedge clk); tx_hold_empty = 1'b0; tx_shift_empty = 1'b1;
    @(negedge clk);
    check("R11 tx bits swapped", {24'd0, line_status}, 32'h40);
    tx_hold_empty = 1'b1;
    @(negedge clk);
    check("R11 tx bits both", {24'd0, line_status}, 32'h60);
    tx_shift_empty = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    rx_pin = 1'b1; loop_tx = 1'b1; loop_en = 1'b0;
    word_len = 2'd3; par_en = 1'b0; par_even = 1'b1;
    rd_data = 1'b0; rd_status = 1'b0;
    tx_hold_empty = 1'b1; tx_shift_empty = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_basic();
    t_widths();
    t_parity();
    t_framing();
    t_break();
    t_overrun();
    t_glitch();
    t_loop();
    t_txbits();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule